// File: doc/BRIEF.md
# Transport Input Byte Router

This block accepts the byte stream that an upstream transport demultiplexer delivers to a video decoder. It sorts each byte into one of three destinations. Video payload goes to a one-entry ready/valid output toward the elementary stream buffer. Presentation and decode timestamp bytes are assembled into a 40-bit timestamp word. System time clock bytes are assembled into a separate 40-bit clock word. The upstream device presents a byte together with a strobe and three class-select lines. The video select is active low. The timestamp and clock selects are active high. The router samples the byte on the rising edge of the strobe.

Every input is sampled with the decoder clock. The rising edge of the strobe is found by comparing the strobe line with a copy of it delayed by one register, so an edge is handled exactly once. An active-low request output tells the upstream device when the video path can take data. The multi-byte words are shifted in with the most significant byte first. Each word is published, together with a one-cycle completion pulse, when its fifth byte arrives. A strobe that selects more than one class is treated as a protocol fault and sets a sticky error flag.

Top module: `tsin_router`

## Requirements
- R1: During reset `up_req_n` is 1 whatever `vs_ready` is, and `vs_valid`, `ts_done`, `stc_done`, `clash_err`, `ts_word` and `stc_word` are all 0.
- R2: Outside reset, `up_req_n` equals the inverse of `vs_ready`: it is 0 when `vs_ready` is 1 and 1 when `vs_ready` is 0.
- R3: A strobe rising edge that has only `up_vid_en_n` low (the value 0 selects video) places `up_data` on `vs_data` with `vs_valid` set from the next clock edge. The byte stays on `vs_data` unchanged until a clock edge that sees `vs_valid` and `vs_ready` both high.
- R4: A video byte that is strobed while a previous byte is held (`vs_valid` is 1 and `vs_ready` is 0) is discarded. The held byte stays on `vs_data`, and only the held byte is delivered.
- R5: Five strobed bytes that arrive while `up_ts_en` is held at 1 form `ts_word`, the first byte in bits 39:32 and the fifth byte in bits 7:0. `ts_word` changes only on the clock edge that takes the fifth byte, and `ts_done` is 1 for exactly the cycle that follows.
- R6: `stc_word` and `stc_done` behave the same way for bytes strobed while `up_stc_en` is held at 1.
- R7: A clock edge that sees a word's enable at 0 clears that word's byte count. Any partial bytes are lost, the published word keeps its old value, and the next byte strobed with the enable set becomes the most significant byte.
- R8: A strobe edge that has two or more class selects active delivers its byte nowhere and does not advance any byte count. It sets `clash_err`, which stays 1 until reset.
- R9: A strobe held high over several clocks is taken once. Changes on `up_data` while the strobe stays high have no effect, and a strobe edge with no class selected has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_data | input | 8 | Byte from the transport demultiplexer |
| up_strobe | input | 1 | Byte strobe; the byte is taken on its rising edge |
| up_vid_en_n | input | 1 | Video class select, active low |
| up_ts_en | input | 1 | Timestamp class select, active high |
| up_stc_en | input | 1 | System clock class select, active high |
| up_req_n | output | 1 | Data request to the upstream device, active low |
| vs_data | output | 8 | Video byte toward the stream buffer |
| vs_valid | output | 1 | Video byte present |
| vs_ready | input | 1 | Stream buffer accepts the byte |
| ts_word | output | 40 | Last complete timestamp word |
| ts_done | output | 1 | One-cycle pulse after a new timestamp word |
| stc_word | output | 40 | Last complete system clock word |
| stc_done | output | 1 | One-cycle pulse after a new clock word |
| clash_err | output | 1 | Sticky flag: a strobe selected more than one class |

## Verification
The hardest situation to reach is a second video byte arriving while the first is still held. A well-behaved upstream device stops strobing once the request goes high, so the stimulus has to break that protocol on purpose. The bench lowers `vs_ready`, strobes two video bytes in a row, and checks that only the first comes out once `vs_ready` returns. The restart of a word's byte count is reached by dropping the timestamp enable for one cycle in the middle of a word. The clash fault is reached by raising two selects at once in the middle of a timestamp word, which also shows that the word's byte count is not disturbed.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  typedef enum logic [2:0] {
    SINK_NONE,
    SINK_VID,
    SINK_TS,
    SINK_STC,
    SINK_CLASH
  } sink_e;

  function automatic logic [1:0] sel_count(input logic v, input logic t, input logic s);
    return {1'b0, v} + {1'b0, t} + {1'b0, s};
  endfunction

  function automatic sink_e classify(input logic hit, input logic v,
                                     input logic t, input logic s);
    if (!hit)                     return SINK_NONE;
    if (sel_count(v, t, s) > 2'd1) return SINK_CLASH;
    if (v)                        return SINK_VID;
    if (t)                        return SINK_TS;
    if (s)                        return SINK_STC;
    return SINK_NONE;
  endfunction

endpackage

// File: rtl/tsr_front.sv
module tsr_front
  import tsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic vid_en_n,
  input  logic ts_en,
  input  logic stc_en,
  output logic edge_ev,
  output logic take_vid,
  output logic take_ts,
  output logic take_stc,
  output logic clash_ev
);
  logic  strobe_q;
  sink_e sink;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign edge_ev  = strobe & ~strobe_q;
  assign sink     = classify(edge_ev, ~vid_en_n, ts_en, stc_en);
  assign take_vid = (sink == SINK_VID);
  assign take_ts  = (sink == SINK_TS);
  assign take_stc = (sink == SINK_STC);
  assign clash_ev = (sink == SINK_CLASH);
endmodule

// File: rtl/tsr_vid_slot.sv
module tsr_vid_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] byte_in,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          load_ev
);
  logic free;

  assign free    = ~valid | ready;
  assign load_ev = take & free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load_ev) begin
      valid <= 1'b1;
      data  <= byte_in;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tsr_word_acc.sv
module tsr_word_acc #(
  parameter int DW     = 8,
  parameter int NBYTES = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_lvl,
  input  logic               take,
  input  logic [DW-1:0]      byte_in,
  output logic [DW*NBYTES-1:0] word,
  output logic               done
);
  localparam int W  = DW * NBYTES;
  localparam int CW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [CW-1:0] LAST = CW'(NBYTES - 1);

  logic [W-1:0]  shreg;
  logic [W-1:0]  shreg_nx;
  logic [CW-1:0] cnt;

  function automatic logic [W-1:0] push_byte(input logic [W-1:0] acc,
                                             input logic [DW-1:0] b);
    return {acc[W-DW-1:0], b};
  endfunction

  assign shreg_nx = push_byte(shreg, byte_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      word  <= '0;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en_lvl) begin
        cnt <= '0;
      end else if (take) begin
        shreg <= shreg_nx;
        if (cnt == LAST) begin
          word <= shreg_nx;
          done <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tsin_router.sv
module tsin_router #(
  parameter int DW     = 8,
  parameter int NBYTES = 5,
  localparam int W     = DW * NBYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] up_data,
  input  logic          up_strobe,
  input  logic          up_vid_en_n,
  input  logic          up_ts_en,
  input  logic          up_stc_en,
  output logic          up_req_n,
  output logic [DW-1:0] vs_data,
  output logic          vs_valid,
  input  logic          vs_ready,
  output logic [W-1:0]  ts_word,
  output logic          ts_done,
  output logic [W-1:0]  stc_word,
  output logic          stc_done,
  output logic          clash_err
);
  logic edge_ev, take_vid, take_ts, take_stc, clash_ev, vid_load;

  tsr_front u_front (
    .clk(clk), .rst_n(rst_n), .strobe(up_strobe),
    .vid_en_n(up_vid_en_n), .ts_en(up_ts_en), .stc_en(up_stc_en),
    .edge_ev(edge_ev), .take_vid(take_vid), .take_ts(take_ts),
    .take_stc(take_stc), .clash_ev(clash_ev)
  );

  tsr_vid_slot #(.DW(DW)) u_vid (
    .clk(clk), .rst_n(rst_n), .take(take_vid), .byte_in(up_data),
    .ready(vs_ready), .valid(vs_valid), .data(vs_data), .load_ev(vid_load)
  );

  tsr_word_acc #(.DW(DW), .NBYTES(NBYTES)) u_ts (
    .clk(clk), .rst_n(rst_n), .en_lvl(up_ts_en), .take(take_ts),
    .byte_in(up_data), .word(ts_word), .done(ts_done)
  );

  tsr_word_acc #(.DW(DW), .NBYTES(NBYTES)) u_stc (
    .clk(clk), .rst_n(rst_n), .en_lvl(up_stc_en), .take(take_stc),
    .byte_in(up_data), .word(stc_word), .done(stc_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        clash_err <= 1'b0;
    else if (clash_ev) clash_err <= 1'b1;
  end

  assign up_req_n = ~(rst_n & vs_ready);
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
  parameter int DW = 8,
  parameter int W  = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vs_ready,
  input logic          up_req_n,
  input logic          vs_valid,
  input logic [DW-1:0] vs_data,
  input logic          ts_done,
  input logic [W-1:0]  ts_word,
  input logic          stc_done,
  input logic [W-1:0]  stc_word,
  input logic          clash_ev,
  input logic          clash_err,
  input logic          edge_ev,
  input logic          vid_load
);
  always_comb begin
    if (!rst_n) p_req_in_reset_r1: assert (up_req_n);
  end

  p_req_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_ready |-> up_req_n);

  p_vid_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_valid && !vs_ready) |=> (vs_valid && $stable(vs_data)));

  p_no_overwrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_valid && !vs_ready) |-> !vid_load);

  p_ts_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_word != $past(ts_word)) |-> ts_done);

  p_ts_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ts_done |=> !ts_done);

  p_stc_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stc_word != $past(stc_word)) |-> stc_done);

  p_clash_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clash_ev |=> clash_err);

  p_clash_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clash_err |=> clash_err);

  p_clash_no_vid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clash_ev |-> !vid_load);

  p_edge_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ev |=> !edge_ev);
endmodule

bind tsin_router tsr_checker #(.DW(DW), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vs_ready(vs_ready), .up_req_n(up_req_n),
  .vs_valid(vs_valid), .vs_data(vs_data), .ts_done(ts_done),
  .ts_word(ts_word), .stc_done(stc_done), .stc_word(stc_word),
  .clash_ev(clash_ev), .clash_err(clash_err), .edge_ev(edge_ev),
  .vid_load(vid_load)
);

// File: tb/sim_tsin_router.sv
`timescale 1ns/1ps
module sim_tsin_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  up_data = '0;
  logic        up_strobe = 1'b0;
  logic        up_vid_en_n = 1'b1;
  logic        up_ts_en = 1'b0;
  logic        up_stc_en = 1'b0;
  logic        up_req_n;
  logic [7:0]  vs_data;
  logic        vs_valid;
  logic        vs_ready = 1'b1;
  logic [39:0] ts_word, stc_word;
  logic        ts_done, stc_done, clash_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0]  vq[$];
  logic [39:0] tq[$];
  logic [39:0] sq[$];

  always #10 clk = ~clk;

  tsin_router u0 (
    .clk(clk), .rst_n(rst_n), .up_data(up_data), .up_strobe(up_strobe),
    .up_vid_en_n(up_vid_en_n), .up_ts_en(up_ts_en), .up_stc_en(up_stc_en),
    .up_req_n(up_req_n), .vs_data(vs_data), .vs_valid(vs_valid),
    .vs_ready(vs_ready), .ts_word(ts_word), .ts_done(ts_done),
    .stc_word(stc_word), .stc_done(stc_done), .clash_err(clash_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: compares design output against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (vs_valid && vs_ready) begin
        if (vq.size() == 0) check("R3 unexpected video byte", {56'd0, vs_data}, 64'hFFFF);
        else check("R3 video byte", {56'd0, vs_data}, {56'd0, vq.pop_front()});
      end
      if (ts_done) begin
        if (tq.size() == 0) check("R5 unexpected ts word", {24'd0, ts_word}, 64'hFFFF_FFFF_FFFF);
        else check("R5 ts word", {24'd0, ts_word}, {24'd0, tq.pop_front()});
      end
      if (stc_done) begin
        if (sq.size() == 0) check("R6 unexpected stc word", {24'd0, stc_word}, 64'hFFFF_FFFF_FFFF);
        else check("R6 stc word", {24'd0, stc_word}, {24'd0, sq.pop_front()});
      end
    end
  end

  // Driver: one strobe pulse of one clock, selects set alongside
  task automatic strobe_byte(input logic [7:0] b, input logic vn, input logic t, input logic s);
    @(negedge clk);
    up_data = b; up_vid_en_n = vn; up_ts_en = t; up_stc_en = s; up_strobe = 1'b1;
    @(negedge clk);
    up_strobe = 1'b0;
  endtask

  task automatic send_vid(input logic [7:0] b, input bit expect_take);
    if (expect_take) vq.push_back(b);
    strobe_byte(b, 1'b0, 1'b0, 1'b0);
    up_vid_en_n = 1'b1;
  endtask

  task automatic send_word(input bit is_stc, input logic [39:0] w);
    if (is_stc) sq.push_back(w); else tq.push_back(w);
    for (int i = 4; i >= 0; i--)
      strobe_byte(w[i*8 +: 8], 1'b1, !is_stc, is_stc);
    @(negedge clk);
    up_ts_en = 1'b0; up_stc_en = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, with vs_ready high
    check("R1 req_n", {63'd0, up_req_n}, 64'd1);
    check("R1 vs_valid", {63'd0, vs_valid}, 64'd0);
    check("R1 done", {62'd0, ts_done, stc_done}, 64'd0);
    check("R1 clash_err", {63'd0, clash_err}, 64'd0);
    check("R1 words", {24'd0, ts_word ^ stc_word}, 64'd0);
    check("R1 ts_word", {24'd0, ts_word}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2
    check("R2 req_n ready", {63'd0, up_req_n}, 64'd0);
    vs_ready = 1'b0;
    #1 check("R2 req_n not ready", {63'd0, up_req_n}, 64'd1);
    vs_ready = 1'b1;
    #1 check("R2 req_n ready again", {63'd0, up_req_n}, 64'd0);

    // R3: plain video bytes
    send_vid(8'hA5, 1); send_vid(8'h3C, 1); send_vid(8'h00, 1); send_vid(8'hFF, 1);
    drain();

    // R3/R4: held byte survives a second strobe
    vs_ready = 1'b0;
    send_vid(8'h11, 1);
    check("R3 held valid", {63'd0, vs_valid}, 64'd1);
    send_vid(8'h22, 0);
    @(negedge clk);
    check("R4 held data kept", {56'd0, vs_data}, 64'h11);
    vs_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R4 nothing after held", {63'd0, vs_valid}, 64'd0);

    // R5 / R6: full words
    send_word(0, 40'h12_34_56_78_9A);
    send_word(1, 40'hFE_DC_BA_98_76);
    send_word(0, 40'h01_02_03_04_05);
    drain();
    check("R5 ts hold", {24'd0, ts_word}, 64'h0102030405);
    check("R6 stc hold", {24'd0, stc_word}, 64'hFEDCBA9876);

    // R7: partial word then enable drop
    for (int i = 0; i < 3; i++) strobe_byte(8'hE0 + 8'(i), 1'b1, 1'b1, 1'b0);
    @(negedge clk); up_ts_en = 1'b0;
    @(negedge clk);
    check("R7 ts unchanged after partial", {24'd0, ts_word}, 64'h0102030405);
    send_word(0, 40'hAA_BB_CC_DD_EE);
    drain();
    for (int i = 0; i < 2; i++) strobe_byte(8'h70 + 8'(i), 1'b1, 1'b0, 1'b1);
    @(negedge clk); up_stc_en = 1'b0;
    send_word(1, 40'h55_66_77_88_99);
    drain();

    // R8: clash in the middle of a ts word
    check("R8 err clear before", {63'd0, clash_err}, 64'd0);
    tq.push_back(40'h10_20_30_40_50);
    strobe_byte(8'h10, 1'b1, 1'b1, 1'b0);
    strobe_byte(8'h20, 1'b1, 1'b1, 1'b0);
    strobe_byte(8'hEE, 1'b0, 1'b1, 1'b0);
    check("R8 err set", {63'd0, clash_err}, 64'd1);
    check("R8 no video", {63'd0, vs_valid}, 64'd0);
    strobe_byte(8'h30, 1'b1, 1'b1, 1'b0);
    strobe_byte(8'h40, 1'b1, 1'b1, 1'b0);
    strobe_byte(8'h50, 1'b1, 1'b1, 1'b0);
    @(negedge clk); up_ts_en = 1'b0;
    strobe_byte(8'h99, 1'b1, 1'b1, 1'b1);
    up_ts_en = 1'b0; up_stc_en = 1'b0;
    drain();
    check("R8 err sticky", {63'd0, clash_err}, 64'd1);
    check("R8 stc untouched", {24'd0, stc_word}, 64'h5566778899);

    // R9: long strobe, data changing while high, and no-select edge
    vq.push_back(8'h5A);
    @(negedge clk);
    up_data = 8'h5A; up_vid_en_n = 1'b0; up_strobe = 1'b1;
    vs_ready = 1'b0;
    @(negedge clk); up_data = 8'h6B;
    @(negedge clk); up_data = 8'h7C;
    check("R9 first byte kept", {56'd0, vs_data}, 64'h5A);
    vs_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 one byte only", {63'd0, vs_valid}, 64'd0);
    up_strobe = 1'b0; up_vid_en_n = 1'b1;
    strobe_byte(8'h33, 1'b1, 1'b0, 1'b0);
    drain();
    check("R9 no-select ignored", {63'd0, vs_valid}, 64'd0);

    check("R3 queue empty", 64'(vq.size()), 64'd0);
    check("R5 queue empty", 64'(tq.size()), 64'd0);
    check("R6 queue empty", 64'(sq.size()), 64'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule